// File: doc/BRIEF.md
# Programmable Interrupt Controller

This block gathers up to 32 interrupt request lines and turns them into two processor-facing interrupt outputs. Software sets each line's active sense and its trigger type, level or edge. It also picks which of the two outputs the line drives: a normal interrupt or a critical (machine-check) one. Each line has a latched status bit and an enable bit. The controller gives a masked view of the two and names the most urgent pending source.

A simple synchronous register bus reaches the controller. It takes a word address, a write strobe and write data, and returns read data in the same cycle. Every register holds one bit per source. Source n sits at bit position 31−n, so source 0 is the most significant bit and the most urgent. A handler reads the pending register to find the source, services it, and writes a one to that source's status bit to acknowledge it.

Top module: `upic_ctrl`

## Requirements
- R1: After reset the status, enable, polarity and trigger registers read 0, the route register reads all ones, and both interrupt outputs and the pending-valid output are low.
- R2: Registers are at word addresses 0 status, 1 enable, 2 polarity, 3 trigger, 4 route, 5 masked status (read-only) and 6 pending (read-only). Source n occupies bit 31−n of every register and of the raw input bus. Writes to addresses 5 and 6 change no register.
- R3: Writing the status register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R4: A polarity bit of 1 makes the source active when its input is high. A polarity bit of 0 makes it active when its input is low.
- R5: A level source (trigger bit 0) sets its status on every cycle its input is active. A clear written while the input stays active leaves the status set.
- R6: An edge source (trigger bit 1) sets its status once, on an inactive-to-active transition. After a clear it stays clear while the input remains active, and it sets again only on the next transition.
- R7: The masked status register reads status AND enable. The pending register reads bit 31 as "any masked source" and bits 4:0 as the lowest-numbered masked source. The same two values appear on `pend_valid` and `pend_id`, and all pending fields are 0 when nothing is masked.
- R8: `irq_norm` is high when an enabled pending source has route bit 1. `irq_crit` is high when an enabled pending source has route bit 0.
- R9: A raw input passes two synchronizer flops. A change of the raw input shows in the status register after the third rising clock edge, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register word address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, same cycle |
| irq_raw | input | 32 | Raw interrupt lines, source n at bit 31−n |
| irq_norm | output | 1 | Normal interrupt request |
| irq_crit | output | 1 | Critical (machine-check) interrupt request |
| pend_valid | output | 1 | Some enabled source is pending |
| pend_id | output | 5 | Lowest-numbered enabled pending source |

## Verification
The hardest case to reach is a clear that arrives while an input is still active. For a level source that clear must be overridden in the same cycle. For an edge source it must stick until a new transition. The stimulus holds a line active across the acknowledge write and reads status both right after the write and several cycles later. It then releases the line and re-asserts it to confirm that a fresh edge latches again. The synchronizer latency is checked by sampling status between the second and third clock edges after a raw change.

// File: rtl/upic_pkg.sv
package upic_pkg;

    localparam int REG_ADDR_W = 3;

    typedef enum logic [REG_ADDR_W-1:0] {
        REG_STATUS  = 3'd0,
        REG_ENABLE  = 3'd1,
        REG_POLAR   = 3'd2,
        REG_TRIG    = 3'd3,
        REG_ROUTE   = 3'd4,
        REG_MASKED  = 3'd5,
        REG_PENDING = 3'd6
    } reg_sel_e;

endpackage

// File: rtl/upic_sync.sv
module upic_sync #(
    parameter int          WIDTH   = 32,
    parameter logic [31:0] RST_VAL = 32'hFFFF_FFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    typedef struct packed {
        logic [WIDTH-1:0] stage1;
        logic [WIDTH-1:0] stage2;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d.stage1 = din;
        s_d.stage2 = s_q.stage1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.stage1 <= RST_VAL[WIDTH-1:0];
            s_q.stage2 <= RST_VAL[WIDTH-1:0];
        end else begin
            s_q <= s_d;
        end
    end

    assign dout = s_q.stage2;

endmodule

// File: rtl/upic_detect.sv
module upic_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic line,
    input  logic polar,
    input  logic edge_mode,
    output logic set
);

    logic active;
    logic prev_d, prev_q;

    always_comb begin
        active = ~(line ^ polar);
        prev_d = active;
        if (edge_mode) begin
            set = active & ~prev_q;
        end else begin
            set = active;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= prev_d;
        end
    end

endmodule

// File: rtl/upic_prio.sv
module upic_prio #(
    parameter int N_SRC = 32,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] masked,
    output logic             valid,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (masked[i]) begin
                valid = 1'b1;
                idx   = IDX_W'(N_SRC - 1 - i);
            end
        end
    end

    // R7: the reported source is set and no lower-numbered source is set
    a_r7_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> ((masked >> (N_SRC - 1 - int'(idx))) == {{(N_SRC-1){1'b0}}, 1'b1}));

    // R7: no valid report while nothing is masked, and the reverse
    a_r7_none_pending: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> (masked == '0 && idx == '0));

endmodule

// File: rtl/upic_ctrl.sv
module upic_ctrl
    import upic_pkg::*;
#(
    parameter int N_SRC = 32,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic                  reg_we,
    input  logic [N_SRC-1:0]      reg_wdata,
    output logic [N_SRC-1:0]      reg_rdata,
    input  logic [N_SRC-1:0]      irq_raw,
    output logic                  irq_norm,
    output logic                  irq_crit,
    output logic                  pend_valid,
    output logic [IDX_W-1:0]      pend_id
);

    typedef struct packed {
        logic [N_SRC-1:0] status;
        logic [N_SRC-1:0] enable;
        logic [N_SRC-1:0] polar;
        logic [N_SRC-1:0] trig;
        logic [N_SRC-1:0] route;
    } regs_t;

    regs_t st_d, st_q;

    logic [N_SRC-1:0] line_sync;
    logic [N_SRC-1:0] set_vec;
    logic [N_SRC-1:0] masked;
    logic [N_SRC-1:0] clr_vec;

    upic_sync #(.WIDTH(N_SRC), .RST_VAL(32'hFFFF_FFFF)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (irq_raw),
        .dout  (line_sync)
    );

    for (genvar b = 0; b < N_SRC; b++) begin : g_src
        upic_detect u_det (
            .clk       (clk),
            .rst_n     (rst_n),
            .line      (line_sync[b]),
            .polar     (st_q.polar[b]),
            .edge_mode (st_q.trig[b]),
            .set       (set_vec[b])
        );
    end

    assign masked = st_q.status & st_q.enable;

    upic_prio #(.N_SRC(N_SRC)) u_prio (
        .clk    (clk),
        .rst_n  (rst_n),
        .masked (masked),
        .valid  (pend_valid),
        .idx    (pend_id)
    );

    always_comb begin
        st_d    = st_q;
        clr_vec = '0;
        if (reg_we) begin
            case (reg_sel_e'(reg_addr))
                REG_STATUS: clr_vec    = reg_wdata;
                REG_ENABLE: st_d.enable = reg_wdata;
                REG_POLAR:  st_d.polar  = reg_wdata;
                REG_TRIG:   st_d.trig   = reg_wdata;
                REG_ROUTE:  st_d.route  = reg_wdata;
                default:    ;
            endcase
        end
        st_d.status = (st_q.status & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.status <= '0;
            st_q.enable <= '0;
            st_q.polar  <= '0;
            st_q.trig   <= '0;
            st_q.route  <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (reg_sel_e'(reg_addr))
            REG_STATUS:  reg_rdata = st_q.status;
            REG_ENABLE:  reg_rdata = st_q.enable;
            REG_POLAR:   reg_rdata = st_q.polar;
            REG_TRIG:    reg_rdata = st_q.trig;
            REG_ROUTE:   reg_rdata = st_q.route;
            REG_MASKED:  reg_rdata = masked;
            REG_PENDING: begin
                reg_rdata = '0;
                reg_rdata[N_SRC-1] = pend_valid;
                reg_rdata[IDX_W-1:0] = pend_id;
            end
            default:     reg_rdata = '0;
        endcase
    end

    assign irq_norm = |(masked & st_q.route);
    assign irq_crit = |(masked & ~st_q.route);

    // R3: a written one clears the bit unless its source set it again
    a_r3_clear_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == REG_STATUS) |=>
        ((st_q.status & $past(reg_wdata) & ~$past(set_vec)) == '0));

    // R5: an active source is latched on the following edge
    a_r5_set_latches: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.status & $past(set_vec)) == $past(set_vec)));

    // R8: nothing enabled means both outputs stay quiet
    a_r8_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.enable == '0) |-> (!irq_norm && !irq_crit && !pend_valid));

    // R8: any request implies a report from the priority encoder
    a_r8_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_norm || irq_crit) |-> pend_valid);

endmodule

// File: tb/upic_ctrl_bench.sv
module upic_ctrl_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] irq_raw = 32'hFFFF_FFFF;
    logic        irq_norm, irq_crit, pend_valid;
    logic [4:0]  pend_id;

    int checks = 0;
    int errors = 0;

    upic_ctrl u_upic_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_addr   (reg_addr),
        .reg_we     (reg_we),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq_raw    (irq_raw),
        .irq_norm   (irq_norm),
        .irq_crit   (irq_crit),
        .pend_valid (pend_valid),
        .pend_id    (pend_id)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] src(int n);
        return 32'h1 << (31 - n);
    endfunction

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        tick(1);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(3'd0, v); check("R1 status", v, 32'h0);
        rd(3'd1, v); check("R1 enable", v, 32'h0);
        rd(3'd2, v); check("R1 polarity", v, 32'h0);
        rd(3'd3, v); check("R1 trigger", v, 32'h0);
        rd(3'd4, v); check("R1 route", v, 32'hFFFF_FFFF);
        check("R1 outputs", {29'd0, irq_norm, irq_crit, pend_valid}, 32'h0);
        rst_n = 1'b1;
        tick(4);
        rd(3'd0, v); check("R1 status after release", v, 32'h0);
    endtask

    task automatic t_level;
        logic [31:0] v;
        irq_raw = irq_raw & ~src(5);
        tick(2);
        rd(3'd0, v); check("R9 status before third edge", v, 32'h0);
        tick(1);
        rd(3'd0, v); check("R9 status after third edge", v, src(5));
        wr(3'd0, src(5));
        rd(3'd0, v); check("R5 clear while active", v, src(5));
        irq_raw = irq_raw & ~src(6);
        tick(3);
        irq_raw = irq_raw | src(5) | src(6);
        tick(3);
        wr(3'd0, src(5));
        rd(3'd0, v); check("R3 clear one keep other", v, src(6));
        wr(3'd0, src(6));
        rd(3'd0, v); check("R3 clear second", v, 32'h0);
    endtask

    task automatic t_polarity;
        logic [31:0] v;
        wr(3'd2, src(7));
        tick(1);
        rd(3'd0, v); check("R4 high input active", v, src(7));
        wr(3'd2, 32'h0);
        tick(1);
        wr(3'd0, src(7));
        tick(2);
        rd(3'd0, v); check("R4 high input idle with low polarity", v, 32'h0);
    endtask

    task automatic t_edge;
        logic [31:0] v;
        wr(3'd3, src(10));
        tick(3);
        rd(3'd0, v); check("R6 idle edge source", v, 32'h0);
        irq_raw = irq_raw & ~src(10);
        tick(3);
        rd(3'd0, v); check("R6 edge latched", v, src(10));
        wr(3'd0, src(10));
        rd(3'd0, v); check("R6 cleared while held", v, 32'h0);
        tick(4);
        rd(3'd0, v); check("R6 stays clear while held", v, 32'h0);
        irq_raw = irq_raw | src(10);
        tick(3);
        irq_raw = irq_raw & ~src(10);
        tick(3);
        rd(3'd0, v); check("R6 new edge latches", v, src(10));
        irq_raw = irq_raw | src(10);
        tick(3);
        wr(3'd0, src(10));
        wr(3'd3, 32'h0);
        rd(3'd0, v); check("R6 final clear", v, 32'h0);
    endtask

    task automatic t_mask_prio;
        logic [31:0] v;
        irq_raw = irq_raw & ~src(3) & ~src(20);
        tick(3);
        rd(3'd0, v); check("R7 both latched", v, src(3) | src(20));
        rd(3'd5, v); check("R7 masked none enabled", v, 32'h0);
        wr(3'd1, src(20));
        rd(3'd5, v); check("R7 masked one", v, src(20));
        rd(3'd6, v); check("R7 pending reg src20", v, 32'h8000_0000 | 32'd20);
        check("R7 pend_id src20", {26'd0, pend_valid, pend_id}, {26'd0, 1'b1, 5'd20});
        check("R8 normal only", {30'd0, irq_norm, irq_crit}, 32'h2);
        wr(3'd1, src(3) | src(20));
        rd(3'd6, v); check("R7 pending reg src3 wins", v, 32'h8000_0000 | 32'd3);
        check("R7 pend_id src3", {27'd0, pend_id}, 32'd3);
        wr(3'd4, ~src(3));
        check("R8 both outputs", {30'd0, irq_norm, irq_crit}, 32'h3);
        wr(3'd1, src(3));
        check("R8 critical only", {30'd0, irq_norm, irq_crit}, 32'h1);
        wr(3'd1, 32'h0);
        check("R8 none enabled", {29'd0, irq_norm, irq_crit, pend_valid}, 32'h0);
        rd(3'd6, v); check("R7 pending reg empty", v, 32'h0);
        wr(3'd5, 32'hFFFF_FFFF);
        wr(3'd6, 32'hFFFF_FFFF);
        rd(3'd1, v); check("R2 read-only writes ignored enable", v, 32'h0);
        rd(3'd4, v); check("R2 read-only writes ignored route", v, ~src(3));
        rd(3'd5, v); check("R2 masked unchanged", v, 32'h0);
        irq_raw = 32'hFFFF_FFFF;
        tick(3);
        wr(3'd4, 32'hFFFF_FFFF);
        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, v); check("R3 clear all", v, 32'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        tick(3);
        t_reset();
        t_level();
        t_polarity();
        t_edge();
        t_mask_prio();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule